// File: doc/BRIEF.md
# Configuration Shadow and Reboot Controller

This block holds two copies of a device's configuration. One is a stored image that keeps its contents through reset, with a modelled programming latency. The other is a volatile working register file that drives the rest of the chip. When reset is released, and when a send-byte command carries the reboot code, the controller raises a busy flag. It counts a fixed number of timing ticks and then copies the whole stored image into the working registers in a single cycle. A write to the stored image also holds busy, for a separate programming time, and the byte is committed only at the end of that time.

The host drives three things: a command byte strobe, a write port into the stored image (16-bit address, window base plus index) and a write port into the working registers. It also presents an address-phase request and receives a refusal flag that is high whenever the controller is busy. The stored image starts from a factory pattern: every byte is zero except index 3Ah, which holds all ones.

Top module: `cfgsh_ctrl`

## Requirements
- R1: After the power-up load completes, every working register reads 00h except index 3Ah, which reads FFh, unless the stored image was changed before.
- R2: From reset release, busy is 1 and ready is 0 until LOAD_TICKS tick pulses have been seen. After that, busy is 0 and ready is 1.
- R3: A command byte of 88h while idle starts a reload lasting LOAD_TICKS ticks. At its end, every working register equals the stored image, which overwrites earlier working writes.
- R4: A command byte other than 88h has no effect: busy stays 0.
- R5: A reboot command that arrives while busy is ignored. The running load ends at its original tick count.
- R6: Working registers keep their values during a load and change only in the cycle the load completes.
- R7: An accepted stored-image write holds busy for PROG_TICKS ticks and commits the byte at the end. The working registers are not changed by it.
- R8: acc_nack equals 1 in any cycle where acc_req is 1 and the block is busy. It is 0 when the block is idle.
- R9: Writes to either array while busy are discarded.
- R10: The stored image survives rst_n. Writing 00h to a stored location clears it, so a later load delivers 00h.
- R11: A working-register write while idle is visible on work_regs one cycle later.
- R12: A stored-image write whose address is outside the window 8000h + index is ignored and does not raise busy.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset (power-up) |
| tick | input | 1 | One-cycle timing pulse counted by the load and programming timers |
| cmd_valid | input | 1 | Send-byte command strobe |
| cmd_byte | input | 8 | Command code, 88h requests reboot |
| nv_wr_en | input | 1 | Stored-image write strobe |
| nv_wr_addr | input | 16 | Stored-image address, window base 8000h plus index |
| nv_wr_data | input | 8 | Stored-image write data |
| wk_wr_en | input | 1 | Working-register write strobe |
| wk_wr_addr | input | 6 | Working-register index |
| wk_wr_data | input | 8 | Working-register write data |
| acc_req | input | 1 | Address-phase access request |
| acc_nack | output | 1 | Access refused because the block is busy |
| work_regs | output | 512 | Working registers, index i at bits [8i+7:8i] |
| busy | output | 1 | Load or programming in progress |
| ready | output | 1 | Idle, with working registers valid |

## Verification
A timer that counts wrongly shows up as busy falling one tick early or late, so the bench checks busy both one tick before and exactly at the expected tick. A lost or misplaced stored-image commit stays hidden until the next reload. For that reason the bench follows every stored write with a reboot or a reset, and then compares the full working file. A reboot that is wrongly accepted while busy restarts the count and keeps busy high past the original end, which the bench catches at that tick.

// File: rtl/cfgsh_pkg.sv
// Package: shared state encoding for the configuration shadow controller.
package cfgsh_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_LOAD = 2'd1,
        ST_PROG = 2'd2
    } cfgsh_state_e;
endpackage

// File: rtl/cfgsh_timer.sv
// Tick counter: counts tick pulses while run is high and flags the pulse
// on which the count reaches target. Assumes target >= 1 and that clr
// is raised when a new interval begins.
module cfgsh_timer #(
    parameter int CNT_W = 9
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             run,
    input  logic             tick,
    input  logic [CNT_W-1:0] target,
    output logic             done
);
    logic [CNT_W-1:0] cnt;

    // Final tick of the interval.
    assign done = run && tick && (cnt == target - CNT_W'(1));

    // Count ticks, restart on clear or completion.
    always_ff @(posedge clk) begin
        if (!rst_n)            cnt <= '0;
        else if (clr || done)  cnt <= '0;
        else if (run && tick)  cnt <= cnt + CNT_W'(1);
    end

    // The count never reaches the target while it is running (R2, R7).
    assert_cnt_bound_R2: assert property (@(posedge clk) disable iff (!rst_n)
        run |-> (cnt < target));
endmodule

// File: rtl/cfgsh_nvstore.sv
// Stored configuration image. Its contents are not cleared by rst_n and
// start from a factory pattern (all zero, one index all ones). A captured
// write is held pending and committed to the array only on commit.
module cfgsh_nvstore #(
    parameter int          NREG        = 64,
    parameter int          DW          = 8,
    parameter int          ADDR_W      = 6,
    parameter int          ONES_IDX    = 58
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cap,
    input  logic [ADDR_W-1:0]  cap_addr,
    input  logic [DW-1:0]      cap_data,
    input  logic               commit,
    output logic [NREG*DW-1:0] image
);
    logic [DW-1:0]     mem [NREG];
    logic              pend_valid;
    logic [ADDR_W-1:0] pend_addr;
    logic [DW-1:0]     pend_data;

    // Factory contents at power-on.
    initial begin
        for (int i = 0; i < NREG; i++) mem[i] = (i == ONES_IDX) ? '1 : '0;
    end

    // Hold the pending write during the programming interval.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_valid <= 1'b0;
            pend_addr  <= '0;
            pend_data  <= '0;
        end else if (cap) begin
            pend_valid <= 1'b1;
            pend_addr  <= cap_addr;
            pend_data  <= cap_data;
        end else if (commit) begin
            pend_valid <= 1'b0;
        end
    end

    // Commit the pending byte into the persistent array.
    always_ff @(posedge clk) begin
        if (commit) mem[pend_addr] <= pend_data;
    end

    // Flatten the array for the loader.
    always_comb begin
        for (int i = 0; i < NREG; i++) image[i*DW +: DW] = mem[i];
    end

    // A commit always has a captured write behind it (R7).
    assert_commit_pending_R7: assert property (@(posedge clk) disable iff (!rst_n)
        commit |-> pend_valid);
endmodule

// File: rtl/cfgsh_workregs.sv
// Working register file: clears on reset, takes the whole image on load,
// otherwise accepts single-register writes. Load has priority.
module cfgsh_workregs #(
    parameter int NREG   = 64,
    parameter int DW     = 8,
    parameter int ADDR_W = 6
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               load,
    input  logic [NREG*DW-1:0] image,
    input  logic               wr,
    input  logic [ADDR_W-1:0]  wr_addr,
    input  logic [DW-1:0]      wr_data,
    output logic [NREG*DW-1:0] regs
);
    localparam logic [ADDR_W:0] NREG_L = NREG[ADDR_W:0];

    // Update the working file from the loader or a direct write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            regs <= '0;
        end else if (load) begin
            regs <= image;
        end else if (wr && ({1'b0, wr_addr} < NREG_L)) begin
            regs[wr_addr*DW +: DW] <= wr_data;
        end
    end
endmodule

// File: rtl/cfgsh_ctrl.sv
// Top: sequences power-up load, command-triggered reload and stored-image
// programming. Busy covers both timed intervals; access is refused then.
// Assumes tick is a single-cycle pulse and that timer intervals are >= 1.
module cfgsh_ctrl
    import cfgsh_pkg::*;
#(
    parameter int          NREG        = 64,
    parameter int          DW          = 8,
    parameter int          NV_AW       = 16,
    parameter logic [15:0] NV_BASE     = 16'h8000,
    parameter int          ONES_IDX    = 58,
    parameter logic [7:0]  REBOOT_CODE = 8'h88,
    parameter int          LOAD_TICKS  = 350,
    parameter int          PROG_TICKS  = 200,
    localparam int         ADDR_W      = $clog2(NREG),
    localparam int         MAX_TICKS   = (LOAD_TICKS > PROG_TICKS) ? LOAD_TICKS : PROG_TICKS,
    localparam int         CNT_W       = $clog2(MAX_TICKS + 1)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               tick,
    input  logic               cmd_valid,
    input  logic [7:0]         cmd_byte,
    input  logic               nv_wr_en,
    input  logic [NV_AW-1:0]   nv_wr_addr,
    input  logic [DW-1:0]      nv_wr_data,
    input  logic               wk_wr_en,
    input  logic [ADDR_W-1:0]  wk_wr_addr,
    input  logic [DW-1:0]      wk_wr_data,
    input  logic               acc_req,
    output logic               acc_nack,
    output logic [NREG*DW-1:0] work_regs,
    output logic               busy,
    output logic               ready
);
    localparam logic [ADDR_W:0] NREG_L = NREG[ADDR_W:0];

    cfgsh_state_e      state;
    logic              is_reboot, nv_in_win, nv_hit, wk_acc;
    logic              tmr_done, load_done, prog_done;
    logic [CNT_W-1:0]  tmr_target;
    logic [NREG*DW-1:0] image;

    // Decode requests that are accepted this cycle.
    assign is_reboot = cmd_valid && (cmd_byte == REBOOT_CODE) && (state == ST_IDLE);
    assign nv_in_win = (nv_wr_addr[NV_AW-1:ADDR_W] == NV_BASE[NV_AW-1:ADDR_W])
                       && ({1'b0, nv_wr_addr[ADDR_W-1:0]} < NREG_L);
    assign nv_hit    = nv_wr_en && nv_in_win && (state == ST_IDLE) && !is_reboot;
    assign wk_acc    = wk_wr_en && (state == ST_IDLE);
    assign load_done = tmr_done && (state == ST_LOAD);
    assign prog_done = tmr_done && (state == ST_PROG);

    // Interval length for the running phase.
    assign tmr_target = (state == ST_LOAD) ? CNT_W'(LOAD_TICKS) : CNT_W'(PROG_TICKS);

    // Phase sequencing; reset behaves as power-up and starts a load.
    always_ff @(posedge clk) begin
        if (!rst_n)          state <= ST_LOAD;
        else if (is_reboot)  state <= ST_LOAD;
        else if (nv_hit)     state <= ST_PROG;
        else if (tmr_done)   state <= ST_IDLE;
    end

    // Status outputs.
    assign busy     = (state != ST_IDLE);
    assign ready    = (state == ST_IDLE);
    assign acc_nack = acc_req && busy;

    cfgsh_timer #(.CNT_W(CNT_W)) i_timer (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr    (is_reboot || nv_hit),
        .run    (state != ST_IDLE),
        .tick   (tick),
        .target (tmr_target),
        .done   (tmr_done)
    );

    cfgsh_nvstore #(.NREG(NREG), .DW(DW), .ADDR_W(ADDR_W), .ONES_IDX(ONES_IDX)) i_nvstore (
        .clk      (clk),
        .rst_n    (rst_n),
        .cap      (nv_hit),
        .cap_addr (nv_wr_addr[ADDR_W-1:0]),
        .cap_data (nv_wr_data),
        .commit   (prog_done),
        .image    (image)
    );

    cfgsh_workregs #(.NREG(NREG), .DW(DW), .ADDR_W(ADDR_W)) i_workregs (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (load_done),
        .image   (image),
        .wr      (wk_acc),
        .wr_addr (wk_wr_addr),
        .wr_data (wk_wr_data),
        .regs    (work_regs)
    );

    // Working file changes only after a finished load or an accepted write (R6).
    assert_work_change_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(work_regs) |-> $past(load_done || wk_acc));

    // An accepted reboot leaves the block busy next cycle (R3).
    assert_reboot_busy_R3: assert property (@(posedge clk) disable iff (!rst_n)
        is_reboot |=> busy);

    // A load only ends on its final tick, whatever commands arrive (R5).
    assert_load_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_LOAD && !tmr_done) |=> (state == ST_LOAD));

    // Programming never touches the working file directly (R7).
    assert_prog_no_work_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_PROG && !wk_acc) |=> $stable(work_regs));
endmodule

// File: tb/test_cfgsh_ctrl.sv
module test_cfgsh_ctrl;
    localparam int NREG = 64, DW = 8, LT = 5, PT = 3;

    logic clk = 0, rst_n = 0, tick = 0, cmd_valid = 0, nv_wr_en = 0, wk_wr_en = 0, acc_req = 0;
    logic [7:0] cmd_byte = 0, nv_wr_data = 0, wk_wr_data = 0;
    logic [15:0] nv_wr_addr = 0;
    logic [5:0] wk_wr_addr = 0;
    logic acc_nack, busy, ready;
    logic [NREG*DW-1:0] work_regs;
    int errors = 0, checks = 0;
    logic [7:0] model [NREG];

    always #2.5 clk = ~clk;

    cfgsh_ctrl #(.LOAD_TICKS(LT), .PROG_TICKS(PT)) i_cfgsh_ctrl (
        .clk(clk), .rst_n(rst_n), .tick(tick), .cmd_valid(cmd_valid), .cmd_byte(cmd_byte),
        .nv_wr_en(nv_wr_en), .nv_wr_addr(nv_wr_addr), .nv_wr_data(nv_wr_data),
        .wk_wr_en(wk_wr_en), .wk_wr_addr(wk_wr_addr), .wk_wr_data(wk_wr_data),
        .acc_req(acc_req), .acc_nack(acc_nack), .work_regs(work_regs),
        .busy(busy), .ready(ready));

    task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [7:0] reg_at(int i);
        return work_regs[i*DW +: DW];
    endfunction

    task automatic check_all(string tag);
        int bad = 0;
        for (int i = 0; i < NREG; i++) if (reg_at(i) !== model[i]) bad++;
        check(tag, bad, 0);
    endtask

    task automatic pulse_tick(int n);
        for (int k = 0; k < n; k++) begin
            @(negedge clk) tick = 1;
            @(negedge clk) tick = 0;
        end
    endtask

    task automatic send_cmd(logic [7:0] c);
        @(negedge clk) begin cmd_valid = 1; cmd_byte = c; end
        @(negedge clk) cmd_valid = 0;
    endtask

    task automatic nv_write(logic [15:0] a, logic [7:0] d);
        @(negedge clk) begin nv_wr_en = 1; nv_wr_addr = a; nv_wr_data = d; end
        @(negedge clk) nv_wr_en = 0;
    endtask

    task automatic wk_write(logic [5:0] a, logic [7:0] d);
        @(negedge clk) begin wk_wr_en = 1; wk_wr_addr = a; wk_wr_data = d; end
        @(negedge clk) wk_wr_en = 0;
    endtask

    // Power-up: busy window, unchanged working file, factory image (R1 R2 R6 R8).
    task automatic t_powerup;
        for (int i = 0; i < NREG; i++) model[i] = 8'h00;
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        check("R2 busy after reset", busy, 1);
        check("R2 ready after reset", ready, 0);
        acc_req = 1; #0.1;
        check("R8 nack while loading", acc_nack, 1);
        acc_req = 0;
        pulse_tick(LT - 1);
        check("R2 busy one tick early", busy, 1);
        check_all("R6 regs held during load");
        pulse_tick(1);
        check("R2 busy cleared", busy, 0);
        check("R2 ready set", ready, 1);
        model[58] = 8'hFF;
        check_all("R1 factory image");
        acc_req = 1; #0.1;
        check("R8 no nack idle", acc_nack, 0);
        acc_req = 0;
    endtask

    // Direct working write (R11).
    task automatic t_work_write;
        wk_write(6'd5, 8'hA5);
        model[5] = 8'hA5;
        check("R11 working write", reg_at(5), 8'hA5);
    endtask

    // Stored write: busy window, writes ignored while busy (R7 R8 R9).
    task automatic t_nv_write;
        nv_write(16'h8005, 8'h3C);
        check("R7 busy during program", busy, 1);
        acc_req = 1; #0.1;
        check("R8 nack while programming", acc_nack, 1);
        acc_req = 0;
        wk_write(6'd6, 8'h77);
        check("R9 working write dropped", reg_at(6), 8'h00);
        nv_write(16'h8007, 8'h99);
        pulse_tick(PT - 1);
        check("R7 busy one tick early", busy, 1);
        pulse_tick(1);
        check("R7 busy cleared", busy, 0);
        check("R7 working unchanged", reg_at(5), 8'hA5);
    endtask

    // Other codes ignored; reboot reload; second reboot ignored (R3 R4 R5 R9).
    task automatic t_reboot;
        send_cmd(8'h87);
        check("R4 other code ignored", busy, 0);
        send_cmd(8'h88);
        check("R3 reboot busy", busy, 1);
        pulse_tick(2);
        send_cmd(8'h88);
        pulse_tick(LT - 3);
        check("R5 still busy before end", busy, 1);
        check("R6 regs held in reload", reg_at(5), 8'hA5);
        pulse_tick(1);
        check("R5 load ended on time", busy, 0);
        model[5] = 8'h3C;
        check_all("R3 image restored R9");
    endtask

    // Illegal window and clear across power cycle (R12 R10).
    task automatic t_persist;
        nv_write(16'h4005, 8'h11);
        check("R12 illegal addr no busy", busy, 0);
        nv_write(16'h803A, 8'h00);
        pulse_tick(PT);
        check("R10 program done", busy, 0);
        @(negedge clk) rst_n = 0;
        repeat (2) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        check("R10 busy after reset", busy, 1);
        pulse_tick(LT);
        model[58] = 8'h00;
        check_all("R10 R12 image survives reset");
    endtask

    initial begin
        t_powerup;
        t_work_write;
        t_nv_write;
        t_reboot;
        t_persist;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog actual=1 expected=0");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule